// File: doc/BRIEF.md
# Sequential Multiply/Divide Unit

A small arithmetic helper that sits on a processor's register bus. Software writes operands into write-only registers, and the block computes either an unsigned W×W product or an unsigned 2W÷W quotient and remainder. It advances by one shift-and-add or shift-and-subtract step on each clock cycle in which the step enable is high. A multiply takes W steps and a divide takes 2W steps. Software reads the 2W-bit result registers one bus word at a time, low word first. A read made before the last step returns an intermediate value.

Writing the second operand starts the operation. The multiplicand and the dividend (two words) are loaded first. The multiplier write then starts a multiply, or the divisor write starts a divide. Both of these start writes also overwrite the product/remainder register at once. If either start write arrives while an operation is running, it still overwrites that register but changes nothing else.

Top module: `seq_muldiv`

## Requirements
- R1: After reset the quotient and product/remainder registers read 0, `rd_data` is 0 and no operation is running.
- R2: A write to the multiplier register (address 1) sets the product/remainder register to 0, whether or not an operation is running.
- R3: A multiplier write while idle sets the quotient register to {multiplier, multiplicand}, where the multiplicand was written at address 0. A multiply then starts and runs for W steps. At the end the product register holds multiplicand×multiplier and the quotient register holds the multiplier, zero-extended.
- R4: A write to the divisor register (address 4) copies the dividend into the product/remainder register, whether or not an operation is running.
- R5: A divisor write while idle starts a divide that runs for 2W steps. At the end the quotient register holds dividend/divisor and the product register holds dividend mod divisor.
- R6: A divide by zero yields a quotient of all ones and a remainder equal to the dividend.
- R7: A multiplier or divisor write during a running operation has no effect other than R2/R4: it does not restart the operation, and it changes neither the quotient register nor the step count.
- R8: Steps occur only in cycles with `step_en` high while an operation runs. In other cycles the result registers hold their values. Once the last step is done, further `step_en` cycles change nothing.
- R9: Read map: address 0 returns the quotient low word, 1 the quotient high word, 2 the product/remainder low word and 3 its high word. Any other address returns 0. `rd_data` is registered: it shows the word selected in a cycle with `rd_en` high after the next clock edge, and it holds its value otherwise.
- R10: The dividend is written as two words: the low word at address 2 and the high word at address 3.
- R11: In a cycle that carries a multiplier or divisor write during an operation, the step is deferred even if `step_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Allows one arithmetic step this cycle |
| addr | input | 3 | Register address for reads and writes |
| wr_en | input | 1 | Write strobe |
| wr_data | input | OP_W | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | OP_W | Registered read data |

## Verification
The properties assume that the bus never asserts a read and a write in the same cycle, and that only one address is in use per cycle. They also assume that `step_en` is the only source of progress, so every step-count property is stated relative to cycles that carry a step and no start write. The stimulus drives each bus access for exactly one cycle. It keeps `step_en` low during writes, except in the one directed case that exercises the deferral rule. It applies exactly the number of steps each operation needs before reading the results, except where the test deliberately adds extra steps to check that the unit has stopped.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  localparam int unsigned MDU_AW = 3;

  localparam logic [MDU_AW-1:0] WA_MCAND   = 3'd0;
  localparam logic [MDU_AW-1:0] WA_MPLIER  = 3'd1;
  localparam logic [MDU_AW-1:0] WA_DVD_LO  = 3'd2;
  localparam logic [MDU_AW-1:0] WA_DVD_HI  = 3'd3;
  localparam logic [MDU_AW-1:0] WA_DIVISOR = 3'd4;

  localparam logic [MDU_AW-1:0] RA_QUO_LO  = 3'd0;
  localparam logic [MDU_AW-1:0] RA_QUO_HI  = 3'd1;
  localparam logic [MDU_AW-1:0] RA_RES_LO  = 3'd2;
  localparam logic [MDU_AW-1:0] RA_RES_HI  = 3'd3;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_MUL  = 2'd1,
    OP_DIV  = 2'd2
  } op_e;
endpackage

// File: rtl/mdu_regs.sv
module mdu_regs
  import mdu_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [MDU_AW-1:0] addr,
  input  logic [W-1:0]      wr_data,
  output logic              wr_mplier,
  output logic              wr_divisor,
  output logic [W-1:0]      mcand,
  output logic [2*W-1:0]    dividend
);
  logic [W-1:0] mcand_q;
  logic [W-1:0] dvd_lo_q;
  logic [W-1:0] dvd_hi_q;

  assign wr_mplier  = wr_en && (addr == WA_MPLIER);
  assign wr_divisor = wr_en && (addr == WA_DIVISOR);

  always_ff @(posedge clk) begin
    if (rst) begin
      mcand_q  <= '0;
      dvd_lo_q <= '0;
      dvd_hi_q <= '0;
    end else if (wr_en) begin
      case (addr)
        WA_MCAND:  mcand_q  <= wr_data;
        WA_DVD_LO: dvd_lo_q <= wr_data;
        WA_DVD_HI: dvd_hi_q <= wr_data;
        default: ;
      endcase
    end
  end

  assign mcand    = mcand_q;
  assign dividend = {dvd_hi_q, dvd_lo_q};
endmodule

// File: rtl/mdu_control.sv
module mdu_control
  import mdu_pkg::*;
#(
  parameter int unsigned W  = 8,
  parameter int unsigned CW = $clog2(2*W+1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step_en,
  input  logic          wr_mplier,
  input  logic          wr_divisor,
  output logic          mul_go,
  output logic          div_go,
  output logic          step_mul,
  output logic          step_div,
  output op_e           op,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] MUL_STEPS = CW'(W);
  localparam logic [CW-1:0] DIV_STEPS = CW'(2*W);

  op_e           op_q;
  logic [CW-1:0] cnt_q;
  logic          idle;
  logic          fire;

  assign idle     = (op_q == OP_IDLE);
  assign mul_go   = wr_mplier && idle;
  assign div_go   = wr_divisor && idle;
  assign fire     = step_en && !idle && !wr_mplier && !wr_divisor;
  assign step_mul = fire && (op_q == OP_MUL);
  assign step_div = fire && (op_q == OP_DIV);

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q  <= OP_IDLE;
      cnt_q <= '0;
    end else if (mul_go) begin
      op_q  <= OP_MUL;
      cnt_q <= MUL_STEPS;
    end else if (div_go) begin
      op_q  <= OP_DIV;
      cnt_q <= DIV_STEPS;
    end else if (fire) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CW'(1)) op_q <= OP_IDLE;
    end
  end

  assign op  = op_q;
  assign cnt = cnt_q;
endmodule

// File: rtl/mdu_datapath.sv
module mdu_datapath #(
  parameter int unsigned W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_mplier,
  input  logic           wr_divisor,
  input  logic           mul_go,
  input  logic           div_go,
  input  logic           step_mul,
  input  logic           step_div,
  input  logic [W-1:0]   bus_data,
  input  logic [W-1:0]   mcand,
  input  logic [2*W-1:0] dividend,
  output logic [2*W-1:0] prod,
  output logic [2*W-1:0] quo
);
  localparam int unsigned RW = 2*W;
  localparam int unsigned SW = 3*W;

  logic [RW-1:0] prod_q;
  logic [RW-1:0] quo_q;
  logic [SW-1:0] shift_q;
  logic [SW-1:0] shr;
  logic          ge;
  logic [RW-1:0] add_res;
  logic [RW-1:0] sub_res;

  assign shr     = shift_q >> 1;
  assign ge      = {{W{1'b0}}, prod_q} >= shr;
  assign add_res = prod_q + shift_q[RW-1:0];
  assign sub_res = prod_q - shr[RW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      prod_q  <= '0;
      quo_q   <= '0;
      shift_q <= '0;
    end else begin
      if (wr_mplier)                prod_q <= '0;
      else if (wr_divisor)          prod_q <= dividend;
      else if (step_mul && quo_q[0]) prod_q <= add_res;
      else if (step_div && ge)      prod_q <= sub_res;

      if (mul_go)        quo_q <= {bus_data, mcand};
      else if (step_mul) quo_q <= quo_q >> 1;
      else if (step_div) quo_q <= {quo_q[RW-2:0], ge};

      if (mul_go)        shift_q <= SW'(bus_data);
      else if (div_go)   shift_q <= {bus_data, {RW{1'b0}}};
      else if (step_mul) shift_q <= shift_q << 1;
      else if (step_div) shift_q <= shr;
    end
  end

  assign prod = prod_q;
  assign quo  = quo_q;
endmodule

// File: rtl/mdu_readport.sv
module mdu_readport
  import mdu_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [MDU_AW-1:0] addr,
  input  logic [2*W-1:0]    quo,
  input  logic [2*W-1:0]    prod,
  output logic [W-1:0]      rd_data
);
  logic [W-1:0] sel;
  logic [W-1:0] rd_q;

  always_comb begin
    case (addr)
      RA_QUO_LO: sel = quo[W-1:0];
      RA_QUO_HI: sel = quo[2*W-1:W];
      RA_RES_LO: sel = prod[W-1:0];
      RA_RES_HI: sel = prod[2*W-1:W];
      default:   sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_q <= '0;
    else if (rd_en) rd_q <= sel;
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/seq_muldiv.sv
module seq_muldiv
  import mdu_pkg::*;
#(
  parameter int unsigned OP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_en,
  input  logic [MDU_AW-1:0] addr,
  input  logic              wr_en,
  input  logic [OP_W-1:0]   wr_data,
  input  logic              rd_en,
  output logic [OP_W-1:0]   rd_data
);
  localparam int unsigned CW = $clog2(2*OP_W+1);

  logic              wr_mplier;
  logic              wr_divisor;
  logic [OP_W-1:0]   mcand;
  logic [2*OP_W-1:0] dividend;
  logic              mul_go;
  logic              div_go;
  logic              step_mul;
  logic              step_div;
  op_e               op;
  logic [CW-1:0]     cnt;
  logic [2*OP_W-1:0] prod;
  logic [2*OP_W-1:0] quo;

  mdu_regs #(.W(OP_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .wr_mplier(wr_mplier), .wr_divisor(wr_divisor),
    .mcand(mcand), .dividend(dividend)
  );

  mdu_control #(.W(OP_W), .CW(CW)) u_ctrl (
    .clk(clk), .rst(rst), .step_en(step_en),
    .wr_mplier(wr_mplier), .wr_divisor(wr_divisor),
    .mul_go(mul_go), .div_go(div_go),
    .step_mul(step_mul), .step_div(step_div),
    .op(op), .cnt(cnt)
  );

  mdu_datapath #(.W(OP_W)) u_dp (
    .clk(clk), .rst(rst),
    .wr_mplier(wr_mplier), .wr_divisor(wr_divisor),
    .mul_go(mul_go), .div_go(div_go),
    .step_mul(step_mul), .step_div(step_div),
    .bus_data(wr_data), .mcand(mcand), .dividend(dividend),
    .prod(prod), .quo(quo)
  );

  mdu_readport #(.W(OP_W)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr),
    .quo(quo), .prod(prod), .rd_data(rd_data)
  );
endmodule

// File: rtl/mdu_checker.sv
module mdu_checker
  import mdu_pkg::*;
#(
  parameter int unsigned W  = 8,
  parameter int unsigned CW = $clog2(2*W+1)
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [MDU_AW-1:0] addr,
  input logic              step_en,
  input op_e               op,
  input logic [CW-1:0]     cnt,
  input logic [2*W-1:0]    prod,
  input logic [2*W-1:0]    quo,
  input logic [2*W-1:0]    dividend
);
  logic start_wr;
  assign start_wr = wr_en && (addr == WA_MPLIER || addr == WA_DIVISOR);

  p_mul_clear_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == WA_MPLIER) |=> (prod == '0));

  p_div_copy_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == WA_DIVISOR) |=> (prod == $past(dividend)));

  p_busy_ignore_r7: assert property (@(posedge clk) disable iff (rst)
    (op != OP_IDLE && start_wr) |=> ($stable(cnt) && $stable(quo) && op == $past(op)));

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!step_en && !wr_en) |=> ($stable(cnt) && $stable(prod) && $stable(quo)));

  p_mul_len_r3: assert property (@(posedge clk) disable iff (rst)
    (op == OP_MUL) |-> (cnt != '0 && cnt <= CW'(W)));

  p_div_len_r5: assert property (@(posedge clk) disable iff (rst)
    (op == OP_DIV) |-> (cnt != '0 && cnt <= CW'(2*W)));
endmodule

bind seq_muldiv mdu_checker #(.W(OP_W), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .step_en(step_en),
  .op(op), .cnt(cnt), .prod(prod), .quo(quo), .dividend(dividend)
);

// File: tb/tb_seq_muldiv.sv
`timescale 1ns/1ps
module tb_seq_muldiv;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         step_en = 1'b0;
  logic [2:0]   addr = '0;
  logic         wr_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic         rd_en = 1'b0;
  logic [W-1:0] rd_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  seq_muldiv #(.OP_W(W)) dut (
    .clk(clk), .rst(rst), .step_en(step_en), .addr(addr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic rd16(input logic [2:0] lo, output logic [15:0] v);
    logic [W-1:0] l, h;
    rd(lo, l);
    rd(lo + 3'd1, h);
    v = {h, l};
  endtask

  task automatic steps(input int n);
    step_en = 1'b1;
    repeat (n) @(negedge clk);
    step_en = 1'b0;
  endtask

  task automatic do_mul(input int a, input int b);
    logic [15:0] q, p;
    wr(3'd0, W'(a));
    wr(3'd1, W'(b));
    steps(W);
    rd16(3'd0, q);
    rd16(3'd2, p);
    chk("R3 mul product", p, 16'(a * b));
    chk("R3 mul quotient", q, 16'(b));
  endtask

  task automatic do_div(input int n, input int d);
    logic [15:0] q, p;
    wr(3'd2, W'(n & 255));
    wr(3'd3, W'(n >> 8));
    wr(3'd4, W'(d));
    steps(2*W);
    rd16(3'd0, q);
    rd16(3'd2, p);
    if (d == 0) begin
      chk("R6 div0 quotient", q, 16'hFFFF);
      chk("R6 div0 remainder", p, 16'(n));
    end else begin
      chk("R5 div quotient", q, 16'(n / d));
      chk("R5 div remainder", p, 16'(n % d));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [W-1:0] b8;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    chk("R1 rd_data after reset", 16'(rd_data), 16'h0);
    rd16(3'd0, v); chk("R1 quotient after reset", v, 16'h0);
    rd16(3'd2, v); chk("R1 product after reset", v, 16'h0);

    // Directed multiply: A=3, B=5, dividend 0x1234 preset
    wr(3'd0, 8'h03);
    wr(3'd2, 8'h34);
    wr(3'd3, 8'h12);
    wr(3'd1, 8'h05);
    rd16(3'd0, v); chk("R3 quotient at start", v, 16'h0503);
    rd16(3'd2, v); chk("R2 product cleared", v, 16'h0000);
    steps(2);
    rd16(3'd2, v); chk("R3 partial product", v, 16'h000F);
    rd16(3'd0, v); chk("R3 partial quotient", v, 16'h0140);
    // divisor write with step_en high while busy
    step_en = 1'b1;
    wr(3'd4, 8'h09);
    step_en = 1'b0;
    rd16(3'd2, v); chk("R4 dividend copied while busy", v, 16'h1234);
    rd16(3'd0, v); chk("R11 step deferred on write", v, 16'h0140);
    steps(4);
    rd16(3'd0, v); chk("R8 quotient after 6 steps", v, 16'h0014);
    wr(3'd1, 8'h77);
    rd16(3'd2, v); chk("R2 product cleared while busy", v, 16'h0000);
    rd16(3'd0, v); chk("R7 no restart on busy write", v, 16'h0014);
    repeat (5) @(negedge clk);
    rd16(3'd0, v); chk("R8 hold without step_en", v, 16'h0014);
    steps(2);
    rd16(3'd0, v); chk("R7 mul ends on original count", v, 16'h0005);
    steps(3);
    rd16(3'd0, v); chk("R8 idle after last step", v, 16'h0005);
    rd16(3'd2, v); chk("R8 idle product hold", v, 16'h0000);

    // Divide interrupted by a multiplier write
    wr(3'd2, 8'd100);
    wr(3'd3, 8'd0);
    wr(3'd4, 8'd7);
    steps(3);
    wr(3'd1, 8'h33);
    steps(13);
    rd16(3'd0, v); chk("R7 div continues after mul write", v, 16'h0000);
    rd16(3'd2, v); chk("R7 remainder from cleared value", v, 16'h0000);

    // Divide with pause in the middle
    wr(3'd2, 8'hE8);
    wr(3'd3, 8'h03);
    wr(3'd4, 8'd13);
    steps(5);
    repeat (10) @(negedge clk);
    steps(11);
    rd16(3'd0, v); chk("R8 paused div quotient", v, 16'(1000 / 13));
    rd16(3'd2, v); chk("R8 paused div remainder", v, 16'(1000 % 13));

    // R9 unmapped read returns 0, R10 byte order
    rd(3'd5, b8); chk("R9 unmapped read", 16'(b8), 16'h0);
    rd(3'd7, b8); chk("R9 unmapped read 7", 16'(b8), 16'h0);
    do_div(16'hAB12, 8'h01);
    rd(3'd1, b8); chk("R10 dividend high word", 16'(b8), 16'h00AB);

    // Sweeps
    for (int a = 0; a < 256; a += 7) begin
      for (int b = 0; b < 256; b += 7) do_mul(a, b);
      do_mul(a, 255);
    end
    do_mul(255, 255);
    for (int n = 0; n <= 65535; n += 997) begin
      for (int d = 0; d < 256; d += 9) do_div(n, d);
      do_div(n, 255);
    end
    do_div(65535, 0);
    do_div(65535, 1);
    do_div(65535, 255);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule